// File: doc/BRIEF.md
# Receive Word-Boundary Bit Slipper

This block sits in a receive datapath right after the deserializer. It takes the raw 64-bit parallel words and shifts the word boundary of the stream one bit at a time. A separate word-alignment engine watches the output and asks for a slip whenever it has not yet found its framing pattern. The slip request comes from another clock domain, or from a slow controller, so the block treats it as asynchronous. It passes the request through a synchronizer in the parallel clock domain. A rising-edge detector then turns each new assertion of the request into one internal slip pulse. Each pulse moves the boundary by exactly one bit.

The output is a 64-bit window taken from two consecutive words, the older word and the newer word, starting at a bit offset. The offset is held in a 6-bit counter that wraps from 63 to 0, so 64 slips bring the stream back to its original framing. A runtime invert control flips every received bit. It corrects a differential pair whose wires were swapped on the board. The inversion is applied to each word as it is captured, before the window is taken. If no slip is ever requested, the data flows through with a fixed latency and an unchanged boundary.

Top module: `rx_word_slipper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `aligned_data` is cleared to all zeros and the boundary offset returns to 0. The first output word after reset is zero.
- R2: With offset 0, a word present on `raw_data` at rising edge E appears unchanged on `aligned_data` after edge E+2.
- R3: With offset k, the output after edge E+2 is bits k to k+63 of the 128-bit value {newer, older}. Here older is the word captured at edge E, in bits 63:0, and newer is the word captured at edge E+1, in bits 127:64. So output bit i is older bit i+k for i+k < 64, and newer bit i+k-64 otherwise.
- R4: Each rising edge of `slip_req`, once synchronized, increases the offset by exactly one.
- R5: Holding `slip_req` high for any number of cycles produces a single slip. No further slip happens until the request goes low and rises again.
- R6: The offset wraps from 63 to 0, so 64 slips restore the original boundary.
- R7: If `slip_req` rises before edge A, `aligned_data` still uses the old offset after edges A, A+1 and A+2, and uses the new offset after edge A+3.
- R8: A request held high for two parallel clock cycles, then low for two, is captured as exactly one slip.
- R9: When `invert_en` is 1 at the edge that captures a word, every bit of that word is inverted before windowing. The control may change from one word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_data | input | 64 | Raw parallel word from the deserializer |
| slip_req | input | 1 | Asynchronous slip request, one slip per rising edge |
| invert_en | input | 1 | 1 inverts every received bit |
| aligned_data | output | 64 | Boundary-shifted, optionally inverted output word |

## Verification
The bench holds the request high for many cycles. A design that slips on level rather than on edge would move the boundary several bits and fail the data check that follows. It slips 63 times and then once more. An offset that saturates, or that wraps to the wrong value, would show a rotated word where the original framing is expected. It measures the exact cycle in which a slip first shows on the output, which catches an added or missing pipeline stage. It also flips the invert control word by word, which exposes inversion applied after windowing or applied to the wrong word of the pair.

// File: rtl/rxs_pkg.sv
// Package: shared constants and helpers for the receive bit slipper.
// Assumes: data width is a power of two so the offset counter spans it exactly.
package rxs_pkg;

    localparam int RXS_DATA_W      = 64;
    localparam int RXS_SYNC_STAGES = 2;

    // Returns the next boundary offset, wrapping from limit-1 back to 0.
    function automatic int rxs_next_offset(input int cur, input int limit);
        if (cur >= limit - 1)
            return 0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/rxs_req_sync.sv
// Module: rxs_req_sync
// Brings the asynchronous slip request into the parallel clock domain through
// a flop chain, then emits a one-cycle pulse on each rising edge it sees.
// Assumes: the request stays high long enough for the chain to sample it
// (two parallel clocks), and STAGES is at least 2.
module rxs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic slip_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // First stage samples the raw asynchronous request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q[0] <= 1'b0;
        else
            chain_q[0] <= req_async;
    end

    // Remaining stages of the synchronizer chain, one flop each.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain_q[s] <= 1'b0;
            else
                chain_q[s] <= chain_q[s-1];
        end
    end

    // Remembers the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else
            last_q <= chain_q[STAGES-1];
    end

    // A rising edge is a high synchronized level after a low one.
    assign slip_pulse = chain_q[STAGES-1] & ~last_q;

    // R5: a held request never yields back-to-back pulses.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |=> !slip_pulse);

endmodule

// File: rtl/rxs_offset_ctr.sv
// Module: rxs_offset_ctr
// Holds the current word-boundary offset and advances it by one on each slip
// pulse, wrapping at the data width.
// Assumes: slip_pulse lasts one cycle per slip event.
module rxs_offset_ctr
    import rxs_pkg::*;
#(
    parameter int DATA_W = RXS_DATA_W,
    localparam int OFF_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slip_pulse,
    output logic [OFF_W-1:0] offset
);

    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(DATA_W - 1);

    logic [OFF_W-1:0] offset_q;

    // Steps the offset on each slip pulse and clears it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offset_q <= '0;
        else if (slip_pulse)
            offset_q <= OFF_W'(rxs_next_offset(int'(offset_q), DATA_W));
    end

    assign offset = offset_q;

    // R4: a slip pulse always moves the offset.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |=> offset_q != $past(offset_q));

    // R4: without a pulse the offset holds.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slip_pulse |=> $stable(offset_q));

    // R6: the top offset wraps to zero.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_pulse && offset_q == OFF_MAX) |=> offset_q == '0);

endmodule

// File: rtl/rxs_window.sv
// Module: rxs_window
// Captures incoming words (optionally inverted), keeps the previous one, and
// selects a DATA_W-bit window from the pair at the given offset through a
// staged logarithmic shifter. The selected word is registered at the output.
// Assumes: offset is below DATA_W and is stable within a cycle.
module rxs_window
    import rxs_pkg::*;
#(
    parameter int DATA_W = RXS_DATA_W,
    localparam int OFF_W = $clog2(DATA_W),
    localparam int CAT_W = 2 * DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              invert_en,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] aligned_data
);

    logic [DATA_W-1:0] in_word;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] prev_q;
    logic [CAT_W-1:0]  stg [0:OFF_W];
    logic [DATA_W-1:0] win;
    logic [DATA_W-1:0] out_q;

    // Applies the runtime polarity flip to the incoming word.
    assign in_word = raw_data ^ {DATA_W{invert_en}};

    // Captures the newest word and ages the previous one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= in_word;
            prev_q <= cur_q;
        end
    end

    // The newer word's top bit can never reach the window, so it is left out.
    assign stg[0] = {cur_q[DATA_W-2:0], prev_q};

    // Each stage shifts right by its power of two when its offset bit is set.
    for (genvar s = 0; s < OFF_W; s++) begin : g_shift
        assign stg[s+1] = offset[s] ? (stg[s] >> (1 << s)) : stg[s];
    end

    assign win = DATA_W'(stg[OFF_W]);

    // Registers the selected window as the block's output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= win;
    end

    assign aligned_data = out_q;

    // R1: the first output after reset is all zeros.
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> out_q == '0);

    // R2: at offset zero the older word passes straight through.
    a_r2_fixed_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (offset == '0) |=> out_q == $past(prev_q));

endmodule

// File: rtl/rx_word_slipper.sv
// Module: rx_word_slipper
// Receive-side word boundary slipper. An asynchronous slip request is
// synchronized and edge-detected, each edge advances a wrapping bit offset,
// and the output is a window over two consecutive (optionally inverted) words.
// Assumes: slip requests are held high for at least two parallel clocks.
module rx_word_slipper
    import rxs_pkg::*;
#(
    parameter int DATA_W      = RXS_DATA_W,
    parameter int SYNC_STAGES = RXS_SYNC_STAGES,
    localparam int OFF_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              slip_req,
    input  logic              invert_en,
    output logic [DATA_W-1:0] aligned_data
);

    logic             slip_pulse;
    logic [OFF_W-1:0] offset;

    // Synchronizer and edge detector for the slip request.
    rxs_req_sync #(
        .STAGES     (SYNC_STAGES)
    ) u_req_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_async  (slip_req),
        .slip_pulse (slip_pulse)
    );

    // Wrapping boundary offset.
    rxs_offset_ctr #(
        .DATA_W     (DATA_W)
    ) u_offset_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .slip_pulse (slip_pulse),
        .offset     (offset)
    );

    // Data capture, inversion and window selection.
    rxs_window #(
        .DATA_W       (DATA_W)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_data     (raw_data),
        .invert_en    (invert_en),
        .offset       (offset),
        .aligned_data (aligned_data)
    );

endmodule

// File: tb/test_rx_word_slipper.sv
`timescale 1ns/1ps
module test_rx_word_slipper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] raw_data = '0;
    logic        slip_req = 1'b0;
    logic        invert_en = 1'b0;
    logic [63:0] aligned_data;

    int n_checks = 0;
    int n_fails  = 0;
    int model_off = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rx_word_slipper i_rx_word_slipper (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_data     (raw_data),
        .slip_req     (slip_req),
        .invert_en    (invert_en),
        .aligned_data (aligned_data)
    );

    function automatic logic [63:0] pick(input logic [63:0] newer, input logic [63:0] older, input int k);
        logic [127:0] cat;
        cat = {newer, older} >> k;
        return cat[63:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1: reset clears the output, also while data is applied.
    task automatic t_reset();
        rst_n = 1'b0;
        raw_data = 64'hDEAD_BEEF_0123_4567;
        repeat (4) @(negedge clk);
        check(aligned_data == '0, "R1 in reset", aligned_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(aligned_data == '0, "R1 after reset", aligned_data, '0);
        model_off = 0;
    endtask

    // Streams words and compares each output with the model (R2, R3, R9).
    // inv_mode: 0 none, 1 all inverted, 2 alternating per word.
    task automatic t_stream(input int n, input int inv_mode, input string req);
        logic [63:0] h1, h2, h3, w, eff;
        bit all_ok;
        logic [63:0] bad_a, bad_e;
        h1 = '0; h2 = '0; h3 = '0;
        all_ok = 1'b1; bad_a = '0; bad_e = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i >= 3 && aligned_data !== pick(h2, h3, model_off)) begin
                if (all_ok) begin
                    bad_a = aligned_data;
                    bad_e = pick(h2, h3, model_off);
                end
                all_ok = 1'b0;
            end
            w = {$urandom, $urandom};
            invert_en = (inv_mode == 1) || (inv_mode == 2 && i[0]);
            raw_data = w;
            eff = invert_en ? ~w : w;
            h3 = h2; h2 = h1; h1 = eff;
        end
        @(negedge clk);
        invert_en = 1'b0;
        check(all_ok, req, bad_a, bad_e);
    endtask

    // R4: one slip request, held high then low.
    task automatic t_slip(input int hold);
        @(negedge clk);
        slip_req = 1'b1;
        repeat (hold) @(negedge clk);
        slip_req = 1'b0;
        repeat (3) @(negedge clk);
        model_off = (model_off + 1) % 64;
    endtask

    // R7: the output changes exactly after edge A+3.
    task automatic t_timing();
        logic [63:0] p;
        p = 64'h8000_0000_0000_0F0F;
        invert_en = 1'b0;
        raw_data = p;
        repeat (4) @(negedge clk);
        slip_req = 1'b1;
        @(negedge clk);
        check(aligned_data == pick(p, p, model_off), "R7 after A", aligned_data, pick(p, p, model_off));
        @(negedge clk);
        check(aligned_data == pick(p, p, model_off), "R7 after A+1", aligned_data, pick(p, p, model_off));
        @(negedge clk);
        check(aligned_data == pick(p, p, model_off), "R7 after A+2", aligned_data, pick(p, p, model_off));
        @(negedge clk);
        model_off = (model_off + 1) % 64;
        check(aligned_data == pick(p, p, model_off), "R7 after A+3", aligned_data, pick(p, p, model_off));
        slip_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_stream(20, 0, "R2 fixed boundary");
        t_stream(20, 1, "R9 all inverted");
        t_stream(20, 2, "R9 alternating inversion");
        t_slip(3);
        t_stream(20, 0, "R4 one slip offset 1");
        t_slip(3);
        t_slip(3);
        t_stream(20, 0, "R3 window offset 3");
        t_slip(12);
        t_stream(20, 0, "R5 long hold gives one slip");
        t_slip(2);
        t_stream(20, 0, "R8 two-cycle request");
        t_timing();
        t_stream(20, 2, "R3 offset 6 with R9 alternating");
        while (model_off != 63) t_slip(2);
        t_stream(20, 0, "R3 offset 63");
        t_slip(2);
        t_stream(20, 0, "R6 wrap to 0");
        for (int j = 0; j < 64; j++) t_slip(2);
        t_stream(20, 1, "R6 64 slips restore boundary");
        t_reset();
        t_stream(12, 0, "R1 offset cleared by reset");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule